// File: doc/BRIEF.md
# Multi-Lane Phase-Coherent Baseband Mixer

This block takes a real sample stream that a time-interleaved converter delivers as a wide word: every clock carries several consecutive samples side by side, one per lane. It mixes that stream with one complex local oscillator running at the full aggregate sample rate, which brings a chosen carrier down to 0 Hz. The result is an in-phase and a quadrature word with the same lane layout. Filtering and decimation are left to the stages that follow.

The oscillator is a single 32-bit phase accumulator. On each valid word it advances by the lane count times the per-sample tuning increment. Each lane adds a fixed offset of its own index times that increment, so all lanes together trace one continuous phase ramp. Each lane addresses its own quarter-wave sine table with the top ten phase bits. It then multiplies its sample by the cosine and by the negated sine, and rescales the products back to sample width.

A typical use: the tuning increment is written once through the load strobe as round(f_carrier / f_aggregate * 2^32). After that the sample words are streamed in with the valid flag.

Top module: `nco_ddc_multilane`

## Requirements
- R1: Reset clears the out_valid flag, the phase accumulator and the tuning increment, so the first word after reset sees phase 0 on every lane until a tuning word is loaded.
- R2: out_valid equals in_valid delayed by exactly 3 clock cycles, and every accepted word yields exactly one output word.
- R3: For the n-th accepted word, lane k uses phase P(n) + k*inc (mod 2^32). P(0) = 0 and P(n+1) = P(n) + 8*inc (mod 2^32), where inc is the increment in force for word n.
- R4: Cycles with in_valid low do not advance the accumulator, so the phase resumes exactly where it stopped.
- R5: Pulsing tune_load captures tune_word as the new increment. A word accepted in the same cycle still uses the old increment, and the following word uses the new one. The accumulator is not reset by this load.
- R6: The table index is phase bits [31:22]. For an index p, sin(p) = round(32767*sin(2*pi*(p+0.5)/1024)), rounded symmetrically about zero, and cos(p) = sin((p+256) mod 1024).
- R7: For each lane, I = floor(x*cos/2^15) and Q = floor(-x*sin/2^15), both as 16-bit two's complement. x is the signed 16-bit sample, and full-scale inputs of either sign do not overflow.
- R8: Lane k occupies bits [16k+15:16k] of in_data, out_i and out_q. Lane 0 is the oldest sample of the word and lane 7 the newest.
- R9: A lane whose sample is zero produces I = 0 and Q = 0 on that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tune_load | input | 1 | Load strobe for the tuning increment |
| tune_word | input | 32 | Per-sample phase increment |
| in_valid | input | 1 | Marks in_data as a valid word |
| in_data | input | 128 | Eight signed 16-bit samples, lane 0 in the low bits |
| out_valid | output | 1 | Marks out_i and out_q as valid |
| out_i | output | 128 | Eight signed 16-bit in-phase results |
| out_q | output | 128 | Eight signed 16-bit quadrature results |

## Verification
A tuning step of exactly one table entry per sample with a full-scale constant input visits all 1024 table indices once. This isolates the table contents and the quadrant folding from the phase arithmetic. An odd increment that wraps the accumulator, together with distinct pseudo-random samples per lane, separates the per-lane offset and the lane ordering from the shared step. Interleaved idle cycles, tuning loads that coincide with a valid word, and a second reset then show phase continuity, the exact point where a new increment takes effect, and the restart at zero. Full-scale samples of both signs and all-zero words probe the rounding and the overflow edge of the scaling.

// File: rtl/nco_ddc_pkg.sv
package nco_ddc_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // One entry of a quarter-wave magnitude table with a half-step offset,
  // rounded to the nearest integer at full scale (2^(amp_w-1) - 1).
  function automatic int quarter_sine(input int j, input int qw, input int amp_w);
    real ang;
    real scale;
    ang   = TWO_PI * (real'(j) + 0.5) / real'(4 * (1 << qw));
    scale = real'((1 << (amp_w - 1)) - 1);
    return $rtoi(scale * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
  parameter int LANES   = 8,
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tune_load,
  input  logic [PHASE_W-1:0]             tune_word,
  input  logic                           in_valid,
  output logic [LANES-1:0][LUT_AW-1:0]   lane_idx,
  output logic                           idx_valid
);

  logic [PHASE_W-1:0] inc_q;
  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] word_step;

  assign word_step = inc_q * PHASE_W'(LANES);

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q     <= '0;
      acc       <= '0;
      idx_valid <= 1'b0;
    end else begin
      idx_valid <= in_valid;
      if (tune_load) inc_q <= tune_word;
      if (in_valid)  acc   <= acc + word_step;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0] lane_phase;
    assign lane_phase = acc + inc_q * PHASE_W'(k);
    always_ff @(posedge clk) begin
      if (in_valid) lane_idx[k] <= lane_phase[PHASE_W-1 -: LUT_AW];
    end
  end

  AST_ACC_RESET: assert property (@(posedge clk) rst |=> (acc == '0)); // R1

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc)); // R4

  AST_TUNE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tune_load |=> $stable(inc_q)); // R5

endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 16
) (
  input  logic              clk,
  input  logic [LUT_AW-1:0] idx,
  output logic [AMP_W-1:0]  sin_mag,
  output logic              sin_neg,
  output logic [AMP_W-1:0]  cos_mag,
  output logic              cos_neg
);

  localparam int QW    = LUT_AW - 2;
  localparam int DEPTH = 1 << QW;

  logic [AMP_W-1:0] qtab [DEPTH];

  initial begin
    for (int j = 0; j < DEPTH; j++) begin
      qtab[j] = AMP_W'(nco_ddc_pkg::quarter_sine(j, QW, AMP_W));
    end
  end

  logic [LUT_AW-1:0] cidx;
  logic [QW-1:0]     s_addr;
  logic [QW-1:0]     c_addr;

  assign cidx   = idx + LUT_AW'(DEPTH);
  assign s_addr = idx[QW]  ? ~idx[QW-1:0]  : idx[QW-1:0];
  assign c_addr = cidx[QW] ? ~cidx[QW-1:0] : cidx[QW-1:0];

  always_ff @(posedge clk) begin
    sin_mag <= qtab[s_addr];
    cos_mag <= qtab[c_addr];
    sin_neg <= idx[LUT_AW-1];
    cos_neg <= cidx[LUT_AW-1];
  end

endmodule

// File: rtl/nco_lane_mixer.sv
module nco_lane_mixer #(
  parameter int SAMP_W = 16,
  parameter int AMP_W  = 16
) (
  input  logic                     clk,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic        [AMP_W-1:0]  sin_mag,
  input  logic                     sin_neg,
  input  logic        [AMP_W-1:0]  cos_mag,
  input  logic                     cos_neg,
  output logic        [SAMP_W-1:0] res_i,
  output logic        [SAMP_W-1:0] res_q
);

  localparam int PROD_W = SAMP_W + AMP_W;

  logic signed [AMP_W-1:0]  c_eff;
  logic signed [AMP_W-1:0]  q_eff;
  logic signed [PROD_W-1:0] prod_i;
  logic signed [PROD_W-1:0] prod_q;

  assign c_eff  = cos_neg ? -$signed(cos_mag) : $signed(cos_mag);
  assign q_eff  = sin_neg ? $signed(sin_mag)  : -$signed(sin_mag);
  assign prod_i = PROD_W'(sample) * PROD_W'(c_eff);
  assign prod_q = PROD_W'(sample) * PROD_W'(q_eff);

  always_ff @(posedge clk) begin
    res_i <= prod_i[AMP_W-1 +: SAMP_W];
    res_q <= prod_q[AMP_W-1 +: SAMP_W];
  end

endmodule

// File: rtl/nco_ddc_multilane.sv
module nco_ddc_multilane #(
  parameter int LANES   = 8,
  parameter int SAMP_W  = 16,
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int AMP_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tune_load,
  input  logic [PHASE_W-1:0]        tune_word,
  input  logic                      in_valid,
  input  logic [LANES*SAMP_W-1:0]   in_data,
  output logic                      out_valid,
  output logic [LANES*SAMP_W-1:0]   out_i,
  output logic [LANES*SAMP_W-1:0]   out_q
);

  localparam int BUS_W = LANES * SAMP_W;

  logic [LANES-1:0][LUT_AW-1:0] lane_idx;
  logic                         s1_valid;
  logic                         s2_valid;
  logic [BUS_W-1:0]             s1_data;
  logic [BUS_W-1:0]             s2_data;

  nco_phase_gen #(
    .LANES  (LANES),
    .PHASE_W(PHASE_W),
    .LUT_AW (LUT_AW)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .tune_load(tune_load),
    .tune_word(tune_word),
    .in_valid (in_valid),
    .lane_idx (lane_idx),
    .idx_valid(s1_valid)
  );

  always_ff @(posedge clk) begin
    if (in_valid) s1_data <= in_data;
    s2_data <= s1_data;
    if (rst) begin
      s2_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s2_valid  <= s1_valid;
      out_valid <= s2_valid;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AMP_W-1:0] sin_mag;
    logic [AMP_W-1:0] cos_mag;
    logic             sin_neg;
    logic             cos_neg;

    nco_sincos_rom #(
      .LUT_AW(LUT_AW),
      .AMP_W (AMP_W)
    ) u_rom (
      .clk    (clk),
      .idx    (lane_idx[k]),
      .sin_mag(sin_mag),
      .sin_neg(sin_neg),
      .cos_mag(cos_mag),
      .cos_neg(cos_neg)
    );

    nco_lane_mixer #(
      .SAMP_W(SAMP_W),
      .AMP_W (AMP_W)
    ) u_mix (
      .clk    (clk),
      .sample ($signed(s2_data[k*SAMP_W +: SAMP_W])),
      .sin_mag(sin_mag),
      .sin_neg(sin_neg),
      .cos_mag(cos_mag),
      .cos_neg(cos_neg),
      .res_i  (out_i[k*SAMP_W +: SAMP_W]),
      .res_q  (out_q[k*SAMP_W +: SAMP_W])
    );
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_data[SAMP_W-1:0] == '0) |=>
    (out_i[SAMP_W-1:0] == '0 && out_q[SAMP_W-1:0] == '0)); // R9

endmodule

// File: tb/tb_nco_ddc_multilane.sv
module tb_nco_ddc_multilane;

  localparam int LN = 8;
  localparam int SW = 16;
  localparam int BW = LN * SW;
  localparam int QD = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tune_load = 1'b0;
  logic [31:0]   tune_word = '0;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_data = '0;
  logic          out_valid;
  logic [BW-1:0] out_i;
  logic [BW-1:0] out_q;

  nco_ddc_multilane dut (
    .clk(clk), .rst(rst), .tune_load(tune_load), .tune_word(tune_word),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_acc = '0;
  logic [31:0] m_inc = '0;
  logic [31:0] seed  = 32'h1234_5678;

  logic [SW-1:0] eq_i [QD][LN];
  logic [SW-1:0] eq_q [QD][LN];
  int            eq_cyc [QD];
  string         eq_tag [QD];
  int wp = 0;
  int rp = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // R6: reference amplitude, rounded symmetrically about zero
  function automatic int exp_sin(input int idx);
    real v;
    v = 32767.0 * $sin(6.283185307179586 * (real'(idx) + 0.5) / 1024.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic logic [15:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:16];
  endfunction

  function automatic logic [BW-1:0] rand_word();
    logic [BW-1:0] r;
    for (int k = 0; k < LN; k++) r[k*SW +: SW] = nxt();
    return r;
  endfunction

  function automatic logic [BW-1:0] fill(input logic [15:0] v);
    logic [BW-1:0] r;
    for (int k = 0; k < LN; k++) r[k*SW +: SW] = v;
    return r;
  endfunction

  task automatic drive(input bit v, input logic [BW-1:0] d, input bit we,
                       input logic [31:0] w, input string tag);
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    tune_load = we;
    tune_word = w;
    if (v) begin
      for (int k = 0; k < LN; k++) begin
        logic [31:0] ph;
        int idx, c, s;
        longint x, pi_, pq;
        ph  = m_acc + m_inc * 32'(k);          // R3 lane offset
        idx = int'(ph[31:22]);                 // R6 index bits
        c   = exp_sin((idx + 256) % 1024);
        s   = exp_sin(idx);
        x   = longint'($signed(d[k*SW +: SW])); // R8 lane slot
        pi_ = x * longint'(c);
        pq  = -x * longint'(s);
        eq_i[wp][k] = 16'(pi_ >>> 15);         // R7 floor scaling
        eq_q[wp][k] = 16'(pq >>> 15);
      end
      eq_cyc[wp] = cyc;
      eq_tag[wp] = tag;
      wp++;
      m_acc = m_acc + m_inc * 32'd8;
    end
    if (we) m_inc = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, '0, "");
  endtask

  // Output monitor: R2 latency and one-to-one, value checks per lane
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (rp == wp) begin
          chk(1'b0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          chk(eq_cyc[rp] + 3 == cyc, "R2", "output cycle", cyc, eq_cyc[rp] + 3);
          for (int k = 0; k < LN; k++) begin
            chk(out_i[k*SW +: SW] == eq_i[rp][k], eq_tag[rp], $sformatf("lane %0d I", k),
                longint'($signed(out_i[k*SW +: SW])), longint'($signed(eq_i[rp][k])));
            chk(out_q[k*SW +: SW] == eq_q[rp][k], eq_tag[rp], $sformatf("lane %0d Q", k),
                longint'($signed(out_q[k*SW +: SW])), longint'($signed(eq_q[rp][k])));
          end
          rp++;
        end
      end else if (rp < wp && eq_cyc[rp] + 3 <= cyc) begin
        chk(1'b0, "R2", "missing output word", 0, 1);
        rp++;
      end
    end
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: valid low straight after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    end

    // R1: no tuning loaded, phase zero on every lane
    drive(1'b1, rand_word(), 1'b0, '0, "R1");
    drive(1'b1, fill(16'h7FFF), 1'b0, '0, "R1");
    idle(4);

    // R6: one table step per sample, full-scale input, all 1024 indices
    drive(1'b0, '0, 1'b1, 32'h0040_0000, "R6");
    for (int n = 0; n < 128; n++) drive(1'b1, fill(16'h7FFF), 1'b0, '0, "R6");
    idle(4);

    // R8: carrier at 3/32 of the sample rate, distinct lane samples
    drive(1'b0, '0, 1'b1, 32'd402653184, "R8");
    for (int n = 0; n < 64; n++) drive(1'b1, rand_word(), 1'b0, '0, "R8");

    // R3: odd increment that wraps the accumulator often
    drive(1'b0, '0, 1'b1, 32'h9E37_79B9, "R3");
    for (int n = 0; n < 96; n++) drive(1'b1, rand_word(), 1'b0, '0, "R3");

    // R4: idle gaps between words must not move the phase
    for (int n = 0; n < 48; n++) begin
      drive(1'b1, rand_word(), 1'b0, '0, "R4");
      idle(int'(nxt() % 16'd4));
    end

    // R5: load coinciding with a valid word, load during a gap
    for (int n = 0; n < 16; n++) begin
      drive(1'b1, rand_word(), 1'b1, {nxt(), nxt()}, "R5");
      drive(1'b1, rand_word(), 1'b0, '0, "R5");
      drive(1'b0, '0, 1'b1, {nxt(), nxt()}, "R5");
      drive(1'b1, rand_word(), 1'b0, '0, "R5");
    end

    // R7: full-scale samples of both signs
    drive(1'b0, '0, 1'b1, 32'h0123_4567, "R7");
    for (int n = 0; n < 32; n++) begin
      drive(1'b1, fill(16'h8000), 1'b0, '0, "R7");
      drive(1'b1, fill(16'h7FFF), 1'b0, '0, "R7");
      drive(1'b1, {8{16'h8000, 16'h7FFF}} ^ {BW{n[0]}}, 1'b0, '0, "R7");
    end

    // R9: zero input words give zero results
    for (int n = 0; n < 16; n++) drive(1'b1, '0, 1'b0, '0, "R9");

    // R2: long back-to-back burst
    for (int n = 0; n < 64; n++) drive(1'b1, rand_word(), 1'b0, '0, "R2");
    idle(6);
    chk(rp == wp, "R2", "words outstanding", wp - rp, 0);

    // R1: reset mid-life clears accumulator and increment
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_acc = '0;
    m_inc = '0;
    rp = wp;
    drive(1'b1, rand_word(), 1'b0, '0, "R1");
    drive(1'b1, rand_word(), 1'b1, 32'h0C00_0000, "R1");
    drive(1'b1, rand_word(), 1'b0, '0, "R1");
    drive(1'b1, rand_word(), 1'b0, '0, "R1");
    idle(6);
    chk(rp == wp, "R2", "words outstanding after reset", wp - rp, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule